// File: doc/BRIEF.md
# Power-Line Timebase BCD Calendar

This block keeps wall-clock time and a calendar in packed BCD registers. It has fields for tenths of a second, seconds, minutes, hours, date, month, two-digit year and day of week. The timebase is the mains supply. An upstream stage squares up the 50 Hz or 60 Hz line waveform, synchronises it into the system clock domain and delivers one single-cycle `line_tick` per line cycle. A prescaler divides those ticks down to tenth-of-second steps.

A host reaches the registers through a byte-wide port with eight registers:

- **Writes:** a write is accepted only while the write-enable input is high. The counter stays frozen from reset until the first accepted write. The end of the write transaction (`bus_stop`) restarts the sub-second phase, so seconds boundaries fall a whole number of seconds after that point.
- **Reads:** a snapshot pulse copies every time register into a shadow buffer, and the read data always comes from that buffer. A rollover during a multi-byte read therefore cannot produce a torn value.
- **Power-fail flag:** this flag is set by reset and cleared by the first accepted write.
- **Seconds strobe:** a one-cycle strobe marks every counted seconds advance, so downstream alarm or daylight-saving logic can evaluate once per second.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 sub-second.

Top module: `mains_bcd_clock`

## Requirements
- R1: With `sel_50hz` = 0 the sub-second register advances once per 6 line ticks. With `sel_50hz` = 1 it advances once per 5 line ticks.
- R2: The sub-second register (address 7) counts 0 to 9 and is read-only. Any accepted write to addresses 0 to 7 clears it to 0 and discards the written data at address 7.
- R3: Seconds and minutes count BCD 00 to 59. Seconds wrap 59→00 when sub-second wraps 9→0, and minutes carry when seconds wrap.
- R4: Hour bit 7 = 1 selects 24-hour mode, in which the hour counts BCD 00 to 23. The day carries on 23→00.
- R5: Hour bit 7 = 0 selects 12-hour mode, with bit 5 as PM flag (1 = PM) and bits 4:0 as BCD hour. The hour runs 12,01,…,11. PM toggles on 11→12, and the day carries only on 11 PM→12 AM.
- R6: The date rolls to 01 after day 31, or day 30 in months 04, 06, 09 and 11. February rolls after day 29 when the year is divisible by 4 (no century rule) and after day 28 otherwise.
- R7: Month 12 rolls to 01 and increments the year. Year 99 wraps to 00. Day of week advances with each day carry, 0..6 with 6→0.
- R8: While `wr_enable` = 0, writes change no register and do not clear the power-fail flag.
- R9: After reset nothing counts until an accepted write is followed by `bus_stop`. Counting stays frozen between the write and the stop. The prescaler and sub-second restart at the stop.
- R10: `pwr_fail` is 1 after reset and drops to 0 on the first accepted write.
- R11: `reg_rdata` returns the register values captured at the last `reg_rd_snap` pulse, regardless of later counting.
- R12: `sec_strobe` is high for exactly one cycle on each counted seconds advance, in the same cycle the new seconds value appears.
- R13: After reset, date reads 01, month reads 01 and every other register reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle pulse per mains cycle, already synchronised |
| sel_50hz | input | 1 | 0 = 60 Hz line, 1 = 50 Hz line |
| wr_enable | input | 1 | Gate that permits writes to the time registers |
| reg_addr | input | 3 | Register address for writes and read-back |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| bus_stop | input | 1 | End of host transaction |
| reg_rd_snap | input | 1 | Copy all time registers into the read shadow |
| reg_rdata | output | 8 | Shadow register selected by `reg_addr` |
| sec_strobe | output | 1 | One-cycle pulse on each counted seconds advance |
| pwr_fail | output | 1 | Set after reset until the first accepted write |

## Verification
The bench loads the counter one second before each boundary and then feeds exactly one second of line ticks. Each field's carry and wrap is therefore isolated in turn:

- **Minutes:** every value is swept, which separates the plain BCD digit step from the 59 wrap.
- **Hours:** every 24-hour value and every 12-hour value in both halves of the day is swept. This shows the PM toggle at 11→12 apart from the day carry at 11 PM.
- **Calendar:** every month is loaded on its last day and on the day before, in a leap year and in a common year. This tells a short-month or February error from an early rollover, and also drives the day-of-week wrap and the year wrap.

Separate tick-count patterns at both line frequencies show the divide ratio, the frozen start, the phase restart at the end of a write, the write gate and the snapshot holding across a rollover.

// File: rtl/mains_bcd_clock.sv
module mains_bcd_clock #(
  parameter int DIV_60HZ = 6,
  parameter int DIV_50HZ = 5,
  parameter int PW       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_tick,
  input  logic       sel_50hz,
  input  logic       wr_enable,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       bus_stop,
  input  logic       reg_rd_snap,
  output logic [7:0] reg_rdata,
  output logic       sec_strobe,
  output logic       pwr_fail
);
  localparam int NREG = 8;
  localparam logic [PW-1:0] LIM60 = PW'(DIV_60HZ - 1);
  localparam logic [PW-1:0] LIM50 = PW'(DIV_50HZ - 1);

  logic [PW-1:0] presc;
  logic [3:0] sub;
  logic [6:0] sec, mnt;
  logic [7:0] hr, yr;
  logic [5:0] date;
  logic [4:0] mon;
  logic [2:0] dow;
  logic running, pending;
  logic [7:0] live [NREG];
  logic [7:0] shd  [NREG];

  function automatic logic [7:0] inc(input logic [7:0] v);
    inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  wire [PW-1:0] lim = sel_50hz ? LIM50 : LIM60;
  wire wr_ok  = reg_wr & wr_enable;
  wire adv    = running & ~pending & ~wr_ok;
  wire tenth  = adv & line_tick & (presc >= lim);
  wire c_s    = tenth & (sub == 4'd9);
  wire c_m    = c_s & (sec == 7'h59);
  wire c_h    = c_m & (mnt == 7'h59);
  wire hr_end = hr[7] ? (hr[5:0] == 6'h23) : (hr[5] && hr[4:0] == 5'h11);
  wire c_d    = c_h & hr_end;

  wire [7:0] sec_i = inc({1'b0, sec});
  wire [7:0] mn_i  = inc({1'b0, mnt});
  wire [7:0] dt_i  = inc({2'b0, date});
  wire [7:0] mo_i  = inc({3'b0, mon});
  wire [7:0] yr_i  = inc(yr);
  wire [7:0] h24_i = inc({2'b0, hr[5:0]});
  wire [7:0] h12_i = inc({3'b0, hr[4:0]});
  wire [7:0] yr_bin = {4'b0, yr[7:4]} * 8'd10 + {4'b0, yr[3:0]};
  wire leap = (yr_bin[1:0] == 2'b00);

  logic [5:0] mlen;
  always_comb begin
    case (mon)
      5'h02:                      mlen = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: mlen = 6'h30;
      default:                    mlen = 6'h31;
    endcase
  end

  wire c_mo = c_d & (date == mlen);
  wire c_y  = c_mo & (mon == 5'h12);

  logic [7:0] hr_nx;
  always_comb begin
    if (hr[7])
      hr_nx = (hr[5:0] == 6'h23) ? 8'h80 : {2'b10, h24_i[5:0]};
    else if (hr[4:0] == 5'h12)
      hr_nx = {2'b00, hr[5], 5'h01};
    else if (hr[4:0] == 5'h11)
      hr_nx = {2'b00, ~hr[5], 5'h12};
    else
      hr_nx = {2'b00, hr[5], h12_i[4:0]};
  end

  always_comb begin
    live[0] = {1'b0, sec};
    live[1] = {1'b0, mnt};
    live[2] = hr;
    live[3] = {2'b0, date};
    live[4] = {3'b0, mon};
    live[5] = yr;
    live[6] = {5'b0, dow};
    live[7] = {4'b0, sub};
  end

  assign reg_rdata = shd[reg_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0; sub <= '0; sec <= '0; mnt <= '0; hr <= '0;
      date <= 6'h01; mon <= 5'h01; yr <= '0; dow <= '0;
      running <= 1'b0; pending <= 1'b0; pwr_fail <= 1'b1; sec_strobe <= 1'b0;
      for (int i = 0; i < NREG; i++) shd[i] <= '0;
    end else begin
      sec_strobe <= c_s;
      if (reg_rd_snap)
        for (int i = 0; i < NREG; i++) shd[i] <= live[i];
      if (wr_ok) begin
        presc <= '0; sub <= '0; pending <= 1'b1; pwr_fail <= 1'b0;
        case (reg_addr)
          3'd0: sec  <= reg_wdata[6:0];
          3'd1: mnt  <= reg_wdata[6:0];
          3'd2: hr   <= {reg_wdata[7], 1'b0, reg_wdata[5:0]};
          3'd3: date <= reg_wdata[5:0];
          3'd4: mon  <= reg_wdata[4:0];
          3'd5: yr   <= reg_wdata;
          3'd6: dow  <= reg_wdata[2:0];
          default: ;
        endcase
      end else if (bus_stop && pending) begin
        pending <= 1'b0; running <= 1'b1; presc <= '0; sub <= '0;
      end else if (adv && line_tick) begin
        presc <= (presc >= lim) ? '0 : presc + 1'b1;
        if (tenth) sub <= (sub == 4'd9) ? 4'd0 : sub + 4'd1;
        if (c_s) sec <= (sec == 7'h59) ? 7'h00 : sec_i[6:0];
        if (c_m) mnt <= (mnt == 7'h59) ? 7'h00 : mn_i[6:0];
        if (c_h) hr <= hr_nx;
        if (c_d) begin
          dow  <= (dow == 3'd6) ? 3'd0 : dow + 3'd1;
          date <= c_mo ? 6'h01 : dt_i[5:0];
        end
        if (c_mo) mon <= c_y ? 5'h01 : mo_i[4:0];
        if (c_y) yr <= (yr == 8'h99) ? 8'h00 : yr_i;
      end
    end
  end

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sub <= 4'd9); // R2
  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running || pending) && !wr_ok |=> $stable({sub, sec, mnt, hr, date, mon, yr, dow})); // R9
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !wr_enable && !line_tick |=> $stable({sub, sec, mnt, hr, date, mon, yr, dow})); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |=> !sec_strobe); // R12
  AST_STROBE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> sub == 4'd0); // R12
  AST_PF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_fail) |-> $past(reg_wr && wr_enable)); // R10
endmodule

// File: tb/mains_bcd_clock_tb_top.sv
module mains_bcd_clock_tb_top;
  logic clk = 0;
  logic rst_n = 0, line_tick = 0, sel_50hz = 0, wr_enable = 0;
  logic reg_wr = 0, bus_stop = 0, reg_rd_snap = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic sec_strobe, pwr_fail;
  int errors = 0, checks = 0, cyc = 0, strobe_hi = 0;

  always #2.5 clk = ~clk;

  mains_bcd_clock dut_i (.clk(clk), .rst_n(rst_n), .line_tick(line_tick), .sel_50hz(sel_50hz),
    .wr_enable(wr_enable), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .bus_stop(bus_stop), .reg_rd_snap(reg_rd_snap), .reg_rdata(reg_rdata),
    .sec_strobe(sec_strobe), .pwr_fail(pwr_fail));

  always @(posedge clk) begin
    strobe_hi <= strobe_hi + int'(sec_strobe);
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int days(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%0h exp=%0h", tag, got, exp);
    end
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic stop();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      line_tick = 1; @(negedge clk); line_tick = 0; @(negedge clk);
    end
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd_snap = 1; @(negedge clk); reg_rd_snap = 0; v = reg_rdata;
  endtask
  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask
  task automatic set_all(input logic [7:0] s, m, h, d, mo, y, dw);
    wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, dw); stop();
  endtask

  logic [7:0] v;
  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R13 reset value", v, (a == 3 || a == 4) ? 8'h01 : 8'h00);
    end
    chk("R10 pwr_fail at reset", {7'b0, pwr_fail}, 8'h01);
    ticks(130);
    rd(7, v); chk("R9 frozen sub", v, 8'h00);
    rd(0, v); chk("R9 frozen sec", v, 8'h00);

    wr(0, 8'h30); stop();
    rd(0, v); chk("R8 gated write", v, 8'h00);
    chk("R8 pwr_fail kept", {7'b0, pwr_fail}, 8'h01);
    ticks(12); rd(7, v); chk("R9 still frozen", v, 8'h00);

    wr_enable = 1;
    wr(0, 8'h10);
    chk("R10 pwr_fail cleared", {7'b0, pwr_fail}, 8'h00);
    ticks(20);
    rd(7, v); chk("R9 frozen before stop", v, 8'h00);
    rd(0, v); chk("R9 written sec", v, 8'h10);
    stop();
    ticks(5); rd(7, v); chk("R1 60Hz 5 ticks", v, 8'h00);
    ticks(1); rd(7, v); chk("R1 60Hz 6 ticks", v, 8'h01);

    wr(7, 8'h09); rd(7, v); chk("R2 read-only sub", v, 8'h00); stop();
    ticks(30); rd(7, v); chk("R2 sub counts", v, 8'h05);
    wr(1, 8'h00); rd(7, v); chk("R2 sub cleared by write", v, 8'h00); stop();

    sel_50hz = 1;
    wr(0, 8'h00); stop();
    ticks(4); rd(7, v); chk("R1 50Hz 4 ticks", v, 8'h00);
    ticks(1); rd(7, v); chk("R1 50Hz 5 ticks", v, 8'h01);
    ticks(45); rd(0, v); chk("R1 50Hz one second", v, 8'h01);
    rd(7, v); chk("R1 50Hz sub wrap", v, 8'h00);
    sel_50hz = 0;

    wr(0, 8'h00); stop(); strobe_hi = 0;
    ticks(180);
    chk("R12 strobe cycles", 8'(strobe_hi), 8'h03);
    rd(0, v); chk("R12 seconds after 3 s", v, 8'h03);

    wr(0, 8'h58); stop();
    rd(0, v); chk("R11 snapshot", v, 8'h58);
    ticks(60); peek(0, v); chk("R11 shadow held", v, 8'h58);
    rd(0, v); chk("R11 new snapshot", v, 8'h59);

    for (int m = 0; m < 60; m++) begin
      set_all(8'h59, bcd(m), 8'h85, 8'h10, 8'h01, 8'h01, 8'h00);
      ticks(60);
      rd(0, v); chk("R3 sec wrap", v, 8'h00);
      rd(1, v); chk("R3 minute step", v, bcd((m + 1) % 60));
      rd(2, v); chk("R3 hour carry", v, (m == 59) ? 8'h86 : 8'h85);
    end

    for (int h = 0; h < 24; h++) begin
      set_all(8'h59, 8'h59, 8'h80 | bcd(h), 8'h10, 8'h01, 8'h01, 8'h00);
      ticks(60);
      rd(2, v); chk("R4 24h step", v, 8'h80 | bcd((h + 1) % 24));
      rd(3, v); chk("R4 24h day carry", v, (h == 23) ? 8'h11 : 8'h10);
    end

    for (int pm = 0; pm < 2; pm++)
      for (int h = 1; h <= 12; h++) begin
        int nh; int npm;
        nh = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        set_all(8'h59, 8'h59, 8'(pm << 5) | bcd(h), 8'h10, 8'h01, 8'h01, 8'h00);
        ticks(60);
        rd(2, v); chk("R5 12h step", v, 8'(npm << 5) | bcd(nh));
        rd(3, v); chk("R5 12h day carry", v, (h == 11 && pm == 1) ? 8'h11 : 8'h10);
      end

    for (int yi = 0; yi < 2; yi++)
      for (int m = 1; m <= 12; m++) begin
        int y; int L;
        y = (yi == 0) ? 1 : 4;
        L = days(m, y);
        set_all(8'h59, 8'h59, 8'h23 | 8'h80, bcd(L - 1), bcd(m), bcd(y), 8'(m % 7));
        ticks(60);
        rd(3, v); chk("R6 no early rollover", v, bcd(L));
        rd(4, v); chk("R6 month held", v, bcd(m));
        set_all(8'h59, 8'h59, 8'h23 | 8'h80, bcd(L), bcd(m), bcd(y), 8'(m % 7));
        ticks(60);
        rd(3, v); chk("R6 date rollover", v, 8'h01);
        rd(4, v); chk("R7 month step", v, bcd(m % 12 + 1));
        rd(5, v); chk("R7 year step", v, bcd((m == 12) ? y + 1 : y));
        rd(6, v); chk("R7 day of week", v, 8'((m + 1) % 7));
      end

    set_all(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06);
    ticks(60);
    rd(5, v); chk("R7 year wrap", v, 8'h00);
    rd(4, v); chk("R7 month wrap", v, 8'h01);
    rd(6, v); chk("R7 dow wrap", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule